// File: doc/BRIEF.md
# CORDIC Quadrature IF Mixer

This block moves a wanted channel centred at an intermediate frequency of 1 MHz down to baseband. It takes one signed real sample per clock from the analog-to-digital converter (clock and sample rate are both 8 MHz) and delivers an in-phase and a quadrature result for every sample. The block's own phase accumulator advances by one eighth of a turn per clock, which is exactly 1 MHz at 8 MHz, and a pipelined rotation-mode CORDIC rotates the vector (sample, 0) by that angle. No sine/cosine table and no multiplier per branch is needed. A single constant multiply on each output undoes the CORDIC gain.

The input, output and phase word lengths are parameters. So are the number of micro-rotations, the guard bits and the precision of the gain constant. The phase word length sets the resolution of the micro-rotation angles on its own. The sample width is chosen by the integrator so that a channel at 3 MHz, ten times stronger than the wanted one, still fits. Results that cannot be represented in the output width are clamped. Downstream filtering and decimation connect directly to the two outputs.

Top module: `cordic_if_mixer`

## Requirements
- R1: The local-oscillator phase starts at 0 after reset and gains 2^(PHASE_W-3) (one eighth of a turn) on every clock edge, wrapping modulo 2^PHASE_W. The sample taken at edge k (k = 0 is the first edge with reset released) is mixed with angle k·45°.
- R2: For that sample x, i_out equals round(x·cos(k·45°)) and q_out equals round(−x·sin(k·45°)), in the LSB of the input. With 12 micro-rotations, a 14-bit phase and 4 guard bits, the error is within 3 LSB for every input value and every one of the eight phases.
- R3: The result for the sample taken at edge k appears on i_out/q_out right after edge k+STAGES+1, and at no other edge.
- R4: out_valid is 0 during reset. It becomes 1 right after edge STAGES+1 (counted from 0 after reset release) and stays 1 until the next reset.
- R5: While out_valid is 0, i_out and q_out are both 0.
- R6: A result above 2^(OUT_W-1)−1 is output as 2^(OUT_W-1)−1, and a result below −2^(OUT_W-1) is output as −2^(OUT_W-1). It never wraps. Example: x = −2^(IN_W-1) at 180° with OUT_W = IN_W gives i_out = 2^(OUT_W-1)−1.
- R7: After the quadrant pre-rotation, the residual angle handed to the first micro-rotation lies in [−90°, +90°). After the last micro-rotation it lies within twice the last stage angle plus STAGES phase LSBs.
- R8: A new sample is accepted on every clock edge without a stall, and the pipeline holds STAGES+2 samples in flight.
- R9: Parameter sets that the arithmetic cannot support (PHASE_W outside 6..30, STAGES outside 4..PHASE_W−1, OUT_W < 4, GUARD < 1, product width above 62) are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_in | input | IN_W | Signed real converter sample |
| i_out | output | OUT_W | Signed in-phase result, same LSB as the input |
| q_out | output | OUT_W | Signed quadrature result, same LSB as the input |
| out_valid | output | 1 | High once the pipeline holds real results |

## Verification
The bench builds the mixer with IN_W = OUT_W = 10, PHASE_W = 14 and STAGES = 12. At this size every one of the 1024 input codes can meet every one of the eight oscillator phases in a single run of 8192 samples. The stimulus sequence is arranged so that each input code meets each phase exactly once. The clamped corners at full negative scale are reached with the output no wider than the input. A second reset followed by a single isolated sample between zeros pins down the exact output cycle and the restart of the valid flag.

// File: rtl/cordic_mix_pkg.sv
package cordic_mix_pkg;

   localparam real PI_R = 3.14159265358979323846;

   // arctangent of 2^-i, converted to phase units of a 2^pw turn
   function automatic int atan_units(input int i, input int pw);
      real t, term, acc, tsq;
      if (i == 0) begin
         acc = PI_R / 4.0;
      end else begin
         t    = 1.0;
         for (int n = 0; n < i; n++) t = t / 2.0;
         tsq  = t * t;
         term = t;
         acc  = 0.0;
         for (int n = 0; n < 40; n++) begin
            if (n % 2 == 0) acc = acc + term / real'(2 * n + 1);
            else            acc = acc - term / real'(2 * n + 1);
            term = term * tsq;
         end
      end
      return int'(acc * real'(longint'(1) << pw) / (2.0 * PI_R));
   endfunction

   // inverse CORDIC gain for a given stage count, scaled by 2^kf
   function automatic int gain_comp(input int stages, input int kf);
      real ksq, r, q;
      ksq = 1.0;
      q   = 1.0;
      for (int i = 0; i < stages; i++) begin
         ksq = ksq / (1.0 + q);
         q   = q / 4.0;
      end
      r = 1.0;
      for (int n = 0; n < 30; n++) r = 0.5 * (r + ksq / r);
      return int'(r * real'(longint'(1) << kf));
   endfunction

endpackage

// File: rtl/cim_phase_acc.sv
module cim_phase_acc #(
   parameter int PHASE_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PHASE_W-1:0] phase
);
   localparam logic [PHASE_W-1:0] STEP = {3'b001, {(PHASE_W-3){1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= '0;
      else        phase <= phase + STEP;
   end
endmodule

// File: rtl/cim_prerot.sv
module cim_prerot #(
   parameter int IN_W    = 12,
   parameter int PHASE_W = 14,
   parameter int IW      = 18,
   parameter int GUARD   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic signed [IN_W-1:0]    sample,
   input  logic        [PHASE_W-1:0] phase,
   output logic signed [IW-1:0]      x0,
   output logic signed [PHASE_W-1:0] z0
);
   localparam int EXT = IW - IN_W - GUARD;

   logic                      flip;
   logic signed [IW-1:0]      x_ext;
   logic signed [PHASE_W-1:0] z_adj;

   always_comb begin
      flip  = phase[PHASE_W-1] ^ phase[PHASE_W-2];
      x_ext = {{EXT{sample[IN_W-1]}}, sample, {GUARD{1'b0}}};
      z_adj = $signed({phase[PHASE_W-1] ^ flip, phase[PHASE_W-2:0]});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x0 <= '0;
         z0 <= '0;
      end else begin
         x0 <= flip ? -x_ext : x_ext;
         z0 <= z_adj;
      end
   end
endmodule

// File: rtl/cim_rot_stage.sv
module cim_rot_stage #(
   parameter int IW    = 18,
   parameter int PW    = 14,
   parameter int SHIFT = 0,
   parameter int ANG   = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [IW-1:0] x_in,
   input  logic signed [IW-1:0] y_in,
   input  logic signed [PW-1:0] z_in,
   output logic signed [IW-1:0] x_out,
   output logic signed [IW-1:0] y_out,
   output logic signed [PW-1:0] z_out
);
   localparam logic signed [PW-1:0] ANG_V = PW'(ANG);

   logic signed [IW-1:0] x_sh, y_sh;
   logic                 ccw;

   always_comb begin
      x_sh = x_in >>> SHIFT;
      y_sh = y_in >>> SHIFT;
      ccw  = ~z_in[PW-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_out <= '0;
         y_out <= '0;
         z_out <= '0;
      end else if (ccw) begin
         x_out <= x_in - y_sh;
         y_out <= y_in + x_sh;
         z_out <= z_in - ANG_V;
      end else begin
         x_out <= x_in + y_sh;
         y_out <= y_in - x_sh;
         z_out <= z_in + ANG_V;
      end
   end
endmodule

// File: rtl/cim_scale_sat.sv
module cim_scale_sat #(
   parameter int IW     = 18,
   parameter int KF     = 16,
   parameter int KQ     = 39797,
   parameter int SHIFT  = 20,
   parameter int OUT_W  = 12,
   parameter bit NEGATE = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [IW-1:0]    v,
   output logic signed [OUT_W-1:0] o
);
   localparam int PROD_W = IW + KF + 1;
   localparam logic signed [PROD_W-1:0] MAXV =
      {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [PROD_W-1:0] MINV =
      {{(PROD_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
   localparam logic signed [PROD_W-1:0] HALF =
      {{(PROD_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
   localparam logic signed [PROD_W-1:0] K_V = PROD_W'(KQ);

   logic signed [PROD_W-1:0] v_ext, prod, prod_s, rounded;

   always_comb begin
      v_ext = {{(PROD_W-IW){v[IW-1]}}, v};
      prod  = v_ext * K_V;
   end

   generate
      if (NEGATE) begin : g_neg
         assign prod_s = -prod;
      end else begin : g_pos
         assign prod_s = prod;
      end
   endgenerate

   assign rounded = (prod_s + HALF) >>> SHIFT;

   always_ff @(posedge clk) begin
      if (!rst_n)              o <= '0;
      else if (rounded > MAXV) o <= MAXV[OUT_W-1:0];
      else if (rounded < MINV) o <= MINV[OUT_W-1:0];
      else                     o <= rounded[OUT_W-1:0];
   end
endmodule

// File: rtl/cordic_if_mixer.sv
module cordic_if_mixer
   import cordic_mix_pkg::*;
#(
   parameter int IN_W    = 12,
   parameter int OUT_W   = 12,
   parameter int PHASE_W = 14,
   parameter int STAGES  = 12,
   parameter int GUARD   = 4,
   parameter int KF      = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [IN_W-1:0]  sample_in,
   output logic signed [OUT_W-1:0] i_out,
   output logic signed [OUT_W-1:0] q_out,
   output logic                    out_valid
);
   localparam int IW    = IN_W + GUARD + 2;
   localparam int SHIFT = KF + GUARD;
   localparam int KQ    = gain_comp(STAGES, KF);

   // R9 elaboration-time parameter checks
   if (PHASE_W < 6 || PHASE_W > 30) begin : g_bad_phase
      $error("cordic_if_mixer: PHASE_W out of range");
   end
   if (STAGES < 4 || STAGES >= PHASE_W) begin : g_bad_stages
      $error("cordic_if_mixer: STAGES out of range");
   end
   if (OUT_W < 4 || GUARD < 1 || IW + KF + 1 > 62) begin : g_bad_width
      $error("cordic_if_mixer: width parameters unsupported");
   end

   logic [PHASE_W-1:0]        phase_q;
   logic signed [IW-1:0]      xs [0:STAGES];
   logic signed [IW-1:0]      ys [0:STAGES];
   logic signed [PHASE_W-1:0] zs [0:STAGES];
   logic [STAGES+1:0]         vpipe;

   cim_phase_acc #(.PHASE_W(PHASE_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .phase(phase_q)
   );

   cim_prerot #(.IN_W(IN_W), .PHASE_W(PHASE_W), .IW(IW), .GUARD(GUARD)) u_pre (
      .clk(clk), .rst_n(rst_n), .sample(sample_in), .phase(phase_q),
      .x0(xs[0]), .z0(zs[0])
   );
   assign ys[0] = '0;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         cim_rot_stage #(
            .IW(IW), .PW(PHASE_W), .SHIFT(s), .ANG(atan_units(s, PHASE_W))
         ) u_rot (
            .clk(clk), .rst_n(rst_n),
            .x_in(xs[s]), .y_in(ys[s]), .z_in(zs[s]),
            .x_out(xs[s+1]), .y_out(ys[s+1]), .z_out(zs[s+1])
         );
      end
   endgenerate

   cim_scale_sat #(.IW(IW), .KF(KF), .KQ(KQ), .SHIFT(SHIFT), .OUT_W(OUT_W),
                   .NEGATE(1'b0)) u_isc (
      .clk(clk), .rst_n(rst_n), .v(xs[STAGES]), .o(i_out)
   );
   cim_scale_sat #(.IW(IW), .KF(KF), .KQ(KQ), .SHIFT(SHIFT), .OUT_W(OUT_W),
                   .NEGATE(1'b1)) u_qsc (
      .clk(clk), .rst_n(rst_n), .v(ys[STAGES]), .o(q_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[STAGES:0], 1'b1};
   end
   assign out_valid = vpipe[STAGES+1];
endmodule

// File: rtl/cordic_if_mixer_chk.sv
module cordic_if_mixer_chk
   import cordic_mix_pkg::*;
#(
   parameter int OUT_W   = 12,
   parameter int PHASE_W = 14,
   parameter int STAGES  = 12
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic        [PHASE_W-1:0] phase,
   input logic signed [PHASE_W-1:0] z0,
   input logic signed [PHASE_W-1:0] z_last,
   input logic                      out_valid,
   input logic signed [OUT_W-1:0]   i_out,
   input logic signed [OUT_W-1:0]   q_out
);
   localparam int DLY = STAGES + 1;
   localparam int CW  = $clog2(DLY + 2) + 1;
   localparam logic [PHASE_W-1:0] STEP = {3'b001, {(PHASE_W-3){1'b0}}};
   localparam logic signed [PHASE_W-1:0] QTR  = {2'b01, {(PHASE_W-2){1'b0}}};
   localparam logic signed [PHASE_W-1:0] NQTR = {2'b11, {(PHASE_W-2){1'b0}}};
   localparam int BOUND = 2 * atan_units(STAGES - 1, PHASE_W) + STAGES;
   localparam logic signed [PHASE_W-1:0] BND_P = PHASE_W'(BOUND);
   localparam logic signed [PHASE_W-1:0] BND_N = PHASE_W'(-BOUND);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (cnt <= CW'(DLY))    cnt <= cnt + 1'b1;
   end

   // R1
   phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> (phase == $past(phase) + STEP));

   // R4
   valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == (cnt > CW'(DLY)));

   // R5
   quiet_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (i_out == '0 && q_out == '0));

   // R7
   prerot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (z0 >= NQTR) && (z0 < QTR));

   // R7
   residual_angle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (z_last <= BND_P) && (z_last >= BND_N));
endmodule

bind cordic_if_mixer cordic_if_mixer_chk #(
   .OUT_W(OUT_W), .PHASE_W(PHASE_W), .STAGES(STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .phase(phase_q), .z0(zs[0]),
   .z_last(zs[STAGES]), .out_valid(out_valid), .i_out(i_out), .q_out(q_out)
);

// File: tb/cordic_if_mixer_bench.sv
module cordic_if_mixer_bench;
   localparam int IN_W    = 10;
   localparam int OUT_W   = 10;
   localparam int PHASE_W = 14;
   localparam int STAGES  = 12;
   localparam int DLY     = STAGES + 1;
   localparam int TOL     = 3;
   localparam int NCODE   = 1 << IN_W;
   localparam int NS      = 8 * NCODE;
   localparam real PI_R   = 3.14159265358979323846;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                    rst_n;
   logic signed [IN_W-1:0]  sample_in;
   logic signed [OUT_W-1:0] i_out, q_out;
   logic                    out_valid;

   int checks = 0;
   int fails  = 0;
   int xs [NS];

   cordic_if_mixer #(
      .IN_W(IN_W), .OUT_W(OUT_W), .PHASE_W(PHASE_W), .STAGES(STAGES)
   ) u_cordic_if_mixer (
      .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
      .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
   );

   function automatic int ideal(input int x, input real c, output bit clipped);
      real v;
      int  r;
      int  mx;
      mx = (1 << (OUT_W - 1)) - 1;
      v  = real'(x) * c;
      r  = int'($floor(v + 0.5));
      clipped = 1'b0;
      if (r > mx)          begin r = mx;      clipped = 1'b1; end
      else if (r < -mx-1)  begin r = -mx - 1; clipped = 1'b1; end
      return r;
   endfunction

   task automatic check(input string req, input int act, input int exp, input int tol);
      int d;
      checks++;
      d = act - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      bit clp;
      int ei, eq;
      for (int n = 0; n < NS; n++)
         xs[n] = ((n % NCODE) + n / NCODE) % NCODE - NCODE / 2;

      rst_n     = 1'b0;
      sample_in = '0;
      repeat (4) @(negedge clk);
      check("R4 reset valid", int'(out_valid), 0, 0);
      check("R5 reset i_out", int'(i_out), 0, 0);
      check("R5 reset q_out", int'(q_out), 0, 0);

      // sweep: every input code meets each of the eight phases once
      rst_n     = 1'b1;
      sample_in = IN_W'(xs[0]);
      for (int e = 1; e <= NS + DLY; e++) begin
         @(negedge clk);
         begin
            int m;
            m = e - 1;
            if (m < DLY) begin
               check("R4 fill valid", int'(out_valid), 0, 0);
               check("R5 fill i_out", int'(i_out), 0, 0);
               check("R5 fill q_out", int'(q_out), 0, 0);
            end else begin
               int n;
               real ang;
               n = m - DLY;
               if (n == 0) check("R4 valid rise", int'(out_valid), 1, 0);
               if (n < NS) begin
                  ang = real'(n % 8) * PI_R / 4.0;
                  ei = ideal(xs[n], $cos(ang), clp);
                  check(clp ? "R6 i_out clamp" : "R1/R2/R8 i_out",
                        int'(i_out), ei, TOL);
                  eq = ideal(xs[n], -$sin(ang), clp);
                  check(clp ? "R6 q_out clamp" : "R1/R2/R8 q_out",
                        int'(q_out), eq, TOL);
               end
               if (n == NS - 1) check("R4 valid held", int'(out_valid), 1, 0);
            end
         end
         sample_in = (e < NS) ? IN_W'(xs[e]) : '0;
      end

      // second reset, then one isolated sample at edge 8 (phase 0)
      rst_n     = 1'b0;
      sample_in = '0;
      repeat (3) @(negedge clk);
      check("R4 re-reset valid", int'(out_valid), 0, 0);
      rst_n = 1'b1;
      for (int e = 1; e <= 8 + DLY + 3; e++) begin
         @(negedge clk);
         if (e - 1 == 8 + DLY - 1) begin
            check("R3 early i_out", int'(i_out), 0, 0);
            check("R4 early valid", int'(out_valid), 1, 0);
         end
         if (e - 1 == 8 + DLY) begin
            check("R3 on-time i_out", int'(i_out), 400, TOL);
            check("R3 on-time q_out", int'(q_out), 0, TOL);
         end
         if (e - 1 == 8 + DLY + 1) check("R3 late i_out", int'(i_out), 0, 0);
         sample_in = (e == 8) ? IN_W'(400) : '0;
      end

      summary();
      $finish;
   end
endmodule